// File: doc/BRIEF.md
# Rotate, Mask and Shift Unit

This block is the rotate, mask and shift stage of a 64-bit integer execution pipeline. Each operation takes a source value, a register-supplied shift amount, an immediate shift count, two mask boundary indices and the old destination value. It returns a 64-bit result and a carry flag. An operation code selects the function. Six functions rotate and then mask: three work on a 32-bit word, three on the whole doubleword, and one of the word forms merges the rotated value into the old destination. Six functions shift: logical left and right on doublewords and on words, an arithmetic right shift on a word, and a left shift of a sign-extended word.

The logic that computes the result is combinational. It sits behind a single output register with a valid/ready handshake on both sides. The producer offers an operation with `in_valid`, and the operation is taken on a clock edge where `in_ready` is high. The result appears one cycle later with `out_valid`. While `out_ready` is low, the result register holds its value and `in_ready` stays low. When the consumer accepts the result in the same cycle as a new operation arrives, the register reloads, so a stream that is never stalled runs at one operation per clock.

Top module: `rms_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, and until an operation is accepted, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. An operation accepted on an edge drives `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `out_result` and `out_carry` stay unchanged. With `out_ready` high and no new operation, `out_valid` falls after the edge.
- R3: Masks use MSB-first numbering, where index 0 is bit 63. mask(b,e) has ones at indices b through e when b <= e. When b > e it wraps: ones from b to 63 and from 0 to e. The word forms use b = 32 + mb[4:0] and e = 32 + me[4:0].
- R4: Op 0 (word rotate-and-mask by immediate): the low 32 bits of the source are copied into both halves, rotated left by imm[4:0], then ANDed with the word mask.
- R5: Op 1 (word rotate-and-insert): the rotation is the same as op 0. The result is (rot & m) | (old & ~m), where m is the word mask.
- R6: Op 2 (word rotate-and-mask by register): the same as op 0, but the rotate count is amt[4:0].
- R7: Ops 3, 4 and 5 rotate the full 64-bit source left by imm. Op 3 masks with mask(mb, 63 - imm). Op 4 masks with mask(mb, 63). Op 5 masks with mask(0, me).
- R8: Ops 6 (left) and 7 (right) shift the 64-bit source logically by amt[5:0]. If amt[6] is 1, the result is 0.
- R9: Ops 8 (left) and 9 (right) shift the low word logically by amt[4:0], and the 32-bit result is zero-extended. If amt[5] is 1, the result is 0.
- R10: Op 10 shifts the low word right arithmetically by amt[4:0] and sign-extends the result from word bit 31. If amt[5] is 1, every result bit equals word bit 31. The carry is 1 only when word bit 31 is 1 and at least one 1 bit has been shifted out.
- R11: Op 11 sign-extends the low word to 64 bits, then shifts it left by imm[5:0].
- R12: Op codes 12 to 15 give result 0. The carry is 0 for every op except op 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 4 | Operation code (0 to 11 defined) |
| in_src | input | 64 | Source value |
| in_amt | input | 7 | Low bits of the register shift amount |
| in_imm | input | 6 | Immediate shift or rotate count |
| in_mb | input | 6 | Mask begin index |
| in_me | input | 6 | Mask end index |
| in_old | input | 64 | Old destination value for insert |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Result |
| out_carry | output | 1 | Carry from the arithmetic shift |

## Verification
The directed vectors test each behaviour separately:
- Mask boundary pairs with begin below, equal to and above end, which separates the wrapped mask from the plain one.
- Doubleword and word shift amounts of 0, of the last in-range value, and with the out-of-range bit set.
- Arithmetic shifts of positive and negative words, with the shifted-out bits all zero or including a one. These separate the sign fill from the carry.
- Undefined codes.

A long pseudo-random stream then mixes every operation code with random mask indices, shift amounts and operands. Throughout the stream the consumer stalls in an irregular pattern, so result holding and back-to-back reloads are compared against the reference model on every clock.

// File: rtl/rms_pkg.sv
package rms_pkg;

  typedef enum logic [3:0] {
    OP_RLW_IMM  = 4'd0,
    OP_RLW_INS  = 4'd1,
    OP_RLW_REG  = 4'd2,
    OP_RLD_CLR  = 4'd3,
    OP_RLD_CLRL = 4'd4,
    OP_RLD_CLRR = 4'd5,
    OP_SHL_D    = 4'd6,
    OP_SHR_D    = 4'd7,
    OP_SHL_W    = 4'd8,
    OP_SHR_W    = 4'd9,
    OP_SRA_W    = 4'd10,
    OP_EXT_SHL  = 4'd11
  } rms_op_e;

  typedef enum logic [1:0] {
    SEL_ZERO  = 2'd0,
    SEL_ROT   = 2'd1,
    SEL_INS   = 2'd2,
    SEL_SHIFT = 2'd3
  } rms_sel_e;

endpackage

// File: rtl/rms_mask_gen.sv
module rms_mask_gen #(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [SHW-1:0]  beg_idx,
  input  logic [SHW-1:0]  end_idx,
  output logic [XLEN-1:0] mask
);
  localparam logic [XLEN-1:0] ALL1 = {XLEN{1'b1}};

  logic [SHW:0]    end_p1;
  logic [XLEN-1:0] from_beg;
  logic [XLEN-1:0] upto_end;

  always_comb begin
    end_p1   = {1'b0, end_idx} + (SHW+1)'(1);
    from_beg = ALL1 >> beg_idx;
    upto_end = ~(ALL1 >> end_p1);
    if (beg_idx <= end_idx) mask = from_beg & upto_end;
    else                    mask = from_beg | upto_end;
  end
endmodule

// File: rtl/rms_rotl.sv
module rms_rotl #(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] din,
  input  logic [SHW-1:0]  cnt,
  output logic [XLEN-1:0] dout
);
  logic [XLEN-1:0] stg [SHW+1];

  assign stg[0] = din;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = cnt[k] ? {stg[k][XLEN-1-S:0], stg[k][XLEN-1:XLEN-S]}
                             : stg[k];
  end

  assign dout = stg[SHW];
endmodule

// File: rtl/rms_shifter.sv
module rms_shifter
  import rms_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW  = $clog2(XLEN),
  localparam int WLEN = XLEN / 2
) (
  input  rms_op_e         op,
  input  logic [XLEN-1:0] src,
  input  logic [SHW:0]    amt,
  input  logic [SHW-1:0]  imm,
  output logic [XLEN-1:0] res,
  output logic            carry
);
  logic [WLEN-1:0]        word;
  logic                   sign;
  logic [SHW-2:0]         nw;
  logic signed [XLEN-1:0] sext;
  logic [WLEN-1:0]        lost_mask;

  always_comb begin
    word      = src[WLEN-1:0];
    sign      = word[WLEN-1];
    nw        = amt[SHW-2:0];
    sext      = {{WLEN{sign}}, word};
    lost_mask = ~({WLEN{1'b1}} << nw);
    res       = '0;
    carry     = 1'b0;
    unique case (op)
      OP_SHL_D:   res = amt[SHW] ? '0 : (src << amt[SHW-1:0]);
      OP_SHR_D:   res = amt[SHW] ? '0 : (src >> amt[SHW-1:0]);
      OP_SHL_W:   res = amt[SHW-1] ? '0 : {{WLEN{1'b0}}, word << nw};
      OP_SHR_W:   res = amt[SHW-1] ? '0 : {{WLEN{1'b0}}, word >> nw};
      OP_SRA_W: begin
        if (amt[SHW-1]) begin
          res   = {XLEN{sign}};
          carry = sign;
        end else begin
          res   = sext >>> nw;
          carry = sign & (|(word & lost_mask));
        end
      end
      OP_EXT_SHL: res = sext << imm;
      default: begin
        res   = '0;
        carry = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rms_unit.sv
module rms_unit
  import rms_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW  = $clog2(XLEN),
  localparam int WLEN = XLEN / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3:0]      in_op,
  input  logic [XLEN-1:0] in_src,
  input  logic [SHW:0]    in_amt,
  input  logic [SHW-1:0]  in_imm,
  input  logic [SHW-1:0]  in_mb,
  input  logic [SHW-1:0]  in_me,
  input  logic [XLEN-1:0] in_old,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic            out_carry
);
  rms_op_e         op;
  rms_sel_e        sel;
  logic [XLEN-1:0] rot_in, rot_out, mask_w;
  logic [SHW-1:0]  rot_n, mb_w, me_w;
  logic [XLEN-1:0] sh_res, res_c;
  logic            sh_carry, carry_c;
  logic            accept;

  assign op = rms_op_e'(in_op);

  // operand routing for the shared rotator and mask generator
  always_comb begin
    rot_in = in_src;
    rot_n  = in_imm;
    mb_w   = in_mb;
    me_w   = in_me;
    sel    = SEL_ZERO;
    unique case (op)
      OP_RLW_IMM, OP_RLW_INS, OP_RLW_REG: begin
        rot_in = {in_src[WLEN-1:0], in_src[WLEN-1:0]};
        rot_n  = (op == OP_RLW_REG) ? {1'b0, in_amt[SHW-2:0]}
                                    : {1'b0, in_imm[SHW-2:0]};
        mb_w   = {1'b1, in_mb[SHW-2:0]};
        me_w   = {1'b1, in_me[SHW-2:0]};
        sel    = (op == OP_RLW_INS) ? SEL_INS : SEL_ROT;
      end
      OP_RLD_CLR: begin
        me_w = ~in_imm;
        sel  = SEL_ROT;
      end
      OP_RLD_CLRL: begin
        me_w = '1;
        sel  = SEL_ROT;
      end
      OP_RLD_CLRR: begin
        mb_w = '0;
        sel  = SEL_ROT;
      end
      OP_SHL_D, OP_SHR_D, OP_SHL_W, OP_SHR_W, OP_SRA_W, OP_EXT_SHL:
        sel = SEL_SHIFT;
      default: sel = SEL_ZERO;
    endcase
  end

  rms_rotl #(.XLEN(XLEN)) rot_i (
    .din  (rot_in),
    .cnt  (rot_n),
    .dout (rot_out)
  );

  rms_mask_gen #(.XLEN(XLEN)) mask_i (
    .beg_idx (mb_w),
    .end_idx (me_w),
    .mask    (mask_w)
  );

  rms_shifter #(.XLEN(XLEN)) shift_i (
    .op    (op),
    .src   (in_src),
    .amt   (in_amt),
    .imm   (in_imm),
    .res   (sh_res),
    .carry (sh_carry)
  );

  always_comb begin
    carry_c = 1'b0;
    unique case (sel)
      SEL_ROT:   res_c = rot_out & mask_w;
      SEL_INS:   res_c = (rot_out & mask_w) | (in_old & ~mask_w);
      SEL_SHIFT: begin
        res_c   = sh_res;
        carry_c = sh_carry;
      end
      default:   res_c = '0;
    endcase
  end

  // single output register with pass-through ready
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_carry  <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= res_c;
      out_carry  <= carry_c;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R2: a stalled result keeps its value
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_carry)));

  // R2: an accepted operation is presented on the next cycle
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R2: a consumed result with nothing new empties the register
  a_r2_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R3: left-clear mask always covers its begin index
  a_r3_mask_begin: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_RLD_CLRL) |-> mask_w[XLEN-1-int'(in_mb)]);

  // R3: right-clear mask reaches the LSB only when the end index is the last one
  a_r3_mask_end: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_RLD_CLRR) |-> (mask_w[0] == (in_me == SHW'(XLEN-1))));

  // R10, R12: carry only from a negative word under the arithmetic shift
  a_r10_carry_src: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && carry_c) |-> (op == OP_SRA_W && in_src[WLEN-1]));

  // R8: out-of-range doubleword left shift yields zero
  a_r8_shl_oob: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_SHL_D && in_amt[SHW]) |=> (out_result == '0));
endmodule

// File: tb/rms_unit_tb_top.sv
`timescale 1ns/1ps
module rms_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [63:0] in_src = '0;
  logic [6:0]  in_amt = '0;
  logic [5:0]  in_imm = '0;
  logic [5:0]  in_mb = '0;
  logic [5:0]  in_me = '0;
  logic [63:0] in_old = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_carry;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit model_on = 0;
  int cyc = 0;

  logic [63:0] exp_res = '0;
  logic        exp_carry = 1'b0;
  bit          exp_valid = 0;
  string       exp_req = "R2";

  always #10 clk = ~clk;

  rms_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src(in_src), .in_amt(in_amt), .in_imm(in_imm),
    .in_mb(in_mb), .in_me(in_me), .in_old(in_old), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_carry(out_carry)
  );

  function automatic logic [63:0] m_rotl(logic [63:0] v, int n);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[(i + n) % 64] = v[i];
    return r;
  endfunction

  // MSB-first mask: index i is vector bit 63-i
  function automatic logic [63:0] m_mask(int b, int e);
    logic [63:0] r;
    for (int i = 0; i < 64; i++)
      r[63-i] = (b <= e) ? (i >= b && i <= e) : (i >= b || i <= e);
    return r;
  endfunction

  function automatic logic [64:0] m_ref(int op, logic [63:0] s, logic [6:0] a,
                                        logic [5:0] im, logic [5:0] mb,
                                        logic [5:0] me, logic [63:0] od);
    logic [63:0] dup, r, m;
    logic [31:0] w;
    longint      sx;
    int          n;
    logic        c;
    w   = s[31:0];
    dup = {w, w};
    sx  = longint'($signed(w));
    c   = 1'b0;
    r   = 64'h0;
    m   = m_mask(32 + int'(mb % 32), 32 + int'(me % 32));
    case (op)
      0: r = m_rotl(dup, int'(im % 32)) & m;
      1: r = (m_rotl(dup, int'(im % 32)) & m) | (od & ~m);
      2: r = m_rotl(dup, int'(a % 32)) & m;
      3: r = m_rotl(s, int'(im)) & m_mask(int'(mb), 63 - int'(im));
      4: r = m_rotl(s, int'(im)) & m_mask(int'(mb), 63);
      5: r = m_rotl(s, int'(im)) & m_mask(0, int'(me));
      6: r = (a >= 64) ? 64'h0 : s << a;
      7: r = (a >= 64) ? 64'h0 : s >> a;
      8: begin n = int'(a % 64); r = (n >= 32) ? 64'h0 : ((64'(w) << n) & 64'hffff_ffff); end
      9: begin n = int'(a % 64); r = (n >= 32) ? 64'h0 : (64'(w) >> n); end
      10: begin
        n = (a % 64 >= 32) ? 32 : int'(a % 32);
        r = 64'(sx >>> n);
        c = w[31] && n > 0 && ((64'(w) & ((64'h1 << n) - 64'h1)) != 64'h0);
      end
      11: r = 64'(sx) << im;
      default: r = 64'h0;
    endcase
    return {c, r};
  endfunction

  function automatic string m_tag(int op);
    case (op)
      0: return "R3+R4";
      1: return "R3+R5";
      2: return "R3+R6";
      3, 4, 5: return "R3+R7";
      6, 7: return "R8";
      8, 9: return "R9";
      10: return "R10";
      11: return "R11";
      default: return "R12";
    endcase
  endfunction

  // per-clock comparison and model update
  always @(negedge clk) begin
    if (model_on && !done) begin
      cyc++;
      checks++;
      if (out_valid !== exp_valid) begin
        failures++;
        $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
      end
      if (exp_valid) begin
        checks++;
        if (out_result !== exp_res || out_carry !== exp_carry) begin
          failures++;
          $display("FAIL %s result actual=%h/%0b expected=%h/%0b",
                   exp_req, out_result, out_carry, exp_res, exp_carry);
        end
      end
      #1 out_ready = (cyc % 7 != 3) && (cyc % 11 != 5);
      #2;
      checks++;
      if (in_ready !== (!exp_valid || out_ready)) begin
        failures++;
        $display("FAIL R2 in_ready actual=%0b expected=%0b", in_ready, !exp_valid || out_ready);
      end
      if (in_valid && (!exp_valid || out_ready)) begin
        {exp_carry, exp_res} = m_ref(int'(in_op), in_src, in_amt, in_imm, in_mb, in_me, in_old);
        exp_req   = m_tag(int'(in_op));
        exp_valid = 1;
      end else if (out_ready) begin
        exp_valid = 0;
      end
    end
  end

  task automatic send(int op, logic [63:0] s, logic [6:0] a, logic [5:0] im,
                      logic [5:0] mb, logic [5:0] me, logic [63:0] od);
    bit acc;
    @(negedge clk);
    #1;
    in_valid = 1'b1; in_op = 4'(op); in_src = s; in_amt = a;
    in_imm = im; in_mb = mb; in_me = me; in_old = od;
    acc = 0;
    while (!acc) begin
      #1 acc = in_ready;
      if (!acc) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R1 during reset
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      failures++;
      $display("FAIL R1 reset actual=%0b/%0b expected=0/1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++; // R1 after release
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      failures++;
      $display("FAIL R1 idle actual=%0b/%0b expected=0/1", out_valid, in_ready);
    end
    model_on = 1;

    // R4 sign-bit extraction and low-half clear
    send(0, 64'h8fffffff, 0, 1, 31, 31, 0);
    send(0, 64'hebeb1888, 0, 0, 16, 31, 0);
    send(0, 64'hf1110001, 0, 1, 0, 30, 0);
    // R3 wrapped word mask (begin > end)
    send(0, 64'h12345678, 0, 4, 28, 3, 0);
    // R5 insert
    send(1, 64'hcc, 0, 16, 8, 15, 64'h7f00ffff);
    send(1, 64'h1, 0, 31, 0, 0, 64'h7fffffff);
    // R6 rotate by register
    send(2, 64'hfebaacda, 16, 0, 8, 11, 0);
    send(2, 64'h111, 1, 0, 0, 31, 0);
    send(2, 64'h11faafff1111aa11, 11, 0, 16, 20, 0);
    // R7 doubleword forms, including wrap and zero rotate
    send(3, 64'h0100ffff00000111, 0, 8, 31, 0, 0);
    send(3, 64'h0100ffff00000fff, 0, 0, 51, 0, 0);
    send(4, 64'h1000dead0000111c, 0, 32, 47, 0, 0);
    send(4, 64'h0100ffff00000111, 0, 8, 44, 0, 0);
    send(5, 64'h0100ffffe0000111, 0, 16, 0, 15, 0);
    send(5, 64'h1000caef0000dead, 0, 32, 0, 32, 0);
    send(3, 64'hdeadbeefcafef00d, 0, 60, 62, 0, 0);
    // R8 doubleword shifts at boundaries
    send(6, 64'hffffffffffffffff, 64, 0, 0, 0, 0);
    send(6, 64'h8000000000000000, 0, 0, 0, 0, 0);
    send(6, 64'h0123456789abcdef, 63, 0, 0, 0, 0);
    send(7, 64'h8000000000000001, 63, 0, 0, 0, 0);
    send(7, 64'h8000000000000001, 127, 0, 0, 0, 0);
    // R9 word shifts
    send(8, 64'h80000000, 0, 0, 0, 0, 0);
    send(8, 64'h80000000, 64, 0, 0, 0, 0);
    send(8, 64'hffffffff00000003, 31, 0, 0, 0, 0);
    send(9, 64'hffffffff80000000, 31, 0, 0, 0, 0);
    send(9, 64'hffffffff80000000, 32, 0, 0, 0, 0);
    // R10 arithmetic shift with and without carry
    send(10, 64'h12345678, 8, 0, 0, 0, 0);
    send(10, 64'h82345678, 8, 0, 0, 0, 0);
    send(10, 64'h82345600, 8, 0, 0, 0, 0);
    send(10, 64'h80000000, 40, 0, 0, 0, 0);
    send(10, 64'h7fffffff, 40, 0, 0, 0, 0);
    send(10, 64'hffffffff, 0, 0, 0, 0, 0);
    // R11 sign-extend then shift
    send(11, 64'h5678, 0, 31, 0, 0, 0);
    send(11, 64'h3ffffd7377f19fdd, 0, 7, 0, 0, 0);
    send(11, 64'h0000010180122900, 0, 0, 0, 0, 0);
    // R12 undefined codes
    for (int k = 12; k < 16; k++) send(k, 64'hffffffffffffffff, 7'h7f, 6'h3f, 1, 2, 64'h5);

    // mixed stream under back-pressure
    for (int i = 0; i < 400; i++) begin
      send(int'($urandom_range(0, 15)), {$urandom, $urandom}, 7'($urandom),
           6'($urandom), 6'($urandom), 6'($urandom), {$urandom, $urandom});
      if (i % 37 == 0) repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule